// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Service

This block is a memory-mapped watchdog that counts down on a slow timebase and insists on being serviced only during an open window at the tail of each period. Software arms it once by writing a magic enable word. From then on it must feed the watchdog with a two-word key sequence. The feed counts as good only when the counter has already fallen into the open window. A feed that lands too soon is a fault. A counter that runs out without a feed is also a fault.

The slow timebase enters as a one-cycle tick strobe in the bus clock domain. The reload value is a 12-bit preload scaled up by a fixed left shift. Software picks the size of the open window and the fault reaction: an interrupt or a reset request. Both choices, and the preload, are sampled only when the counter reloads. A status bit records each fault, and software clears it by writing one to it. The live counter can be read back at any time.

Top module: `win_wdog`

## Requirements
- R1: After reset the block is disabled, the counter and the status register read 0, the preload reads 0xFFF, the reaction and window registers read 0, and both fault outputs are low.
- R2: Writing exactly 0xA98559DA to offset 0x90 enables the watchdog and loads the counter with preload << PRE_SHIFT. Any other value written there does nothing.
- R3: Once enabled, the watchdog cannot be switched off. Later writes to 0x90 neither disable it nor reload it.
- R4: While enabled, each tick lowers the counter (read at offset 0xA0) by one. A tick that finds the counter at zero, after it got there without a service, raises the fault (status bit 1 at offset 0x98) once.
- R5: A service is a write of 0xE51A to offset 0x9C followed by a write of 0xA35C to the same offset. It reloads the counter. Key writes made before enabling are ignored.
- R6: A key write that is not the expected next key returns the sequence to idle without a reload. This includes 0xE51A written while already armed.
- R7: A service that completes while the counter is above the window threshold raises the fault, and the counter still reloads.
- R8: The window code at offset 0xA8 sets threshold = reload >> k, with k as follows: 0x50 gives k=1 (half the period, the largest window), 0x05 gives k=2, 0x06 gives k=3, 0x07 gives k=4, and any other code gives k=1.
- R9: If the reaction code at 0xA4 is 0x0A, the fault level drives err_irq. Any other code drives rst_req instead. The two outputs are registered and follow the status bit on the same clock edge.
- R10: Writes to preload, window and reaction take effect only at the next reload (enable or service).
- R11: Writing 1 to status bit 1 clears it. A fault raised in the same cycle wins over the clear.
- R12: Offset 0x90 reads back the enable state in bit 0.
- R13: Read data is registered and appears the cycle after rd_en. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe from the slow timebase |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err_irq | output | 1 | Fault level when interrupt reaction is selected |
| rst_req | output | 1 | Fault level when reset reaction is selected |

## Verification
The assertions assume that the bus presents at most one access per cycle, that tick is a single-cycle strobe in the clk domain, and that addr holds a defined value whenever wr_en or rd_en is high. The bench drives exactly one operation per cycle from a task, always with a defined address. It keeps the preload small, so expiry, early service and in-window service all occur many times within the random run. The random run also places clears next to faults, so the case where a fault and a clear share a cycle gets exercised.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h90;
  localparam logic [7:0] OFS_PRE   = 8'h94;
  localparam logic [7:0] OFS_STAT  = 8'h98;
  localparam logic [7:0] OFS_KEY   = 8'h9C;
  localparam logic [7:0] OFS_CNT   = 8'hA0;
  localparam logic [7:0] OFS_REACT = 8'hA4;
  localparam logic [7:0] OFS_WIN   = 8'hA8;

  localparam logic [31:0] EN_MAGIC  = 32'hA985_59DA;
  localparam logic [31:0] FEED_ONE  = 32'h0000_E51A;
  localparam logic [31:0] FEED_TWO  = 32'h0000_A35C;
  localparam logic [7:0]  REACT_IRQ = 8'h0A;
  localparam int          ERR_BIT   = 1;

  typedef enum logic {FEED_IDLE, FEED_ARMED} feed_st_t;

  function automatic logic [2:0] win_shift(input logic [7:0] code);
    case (code)
      8'h50:   win_shift = 3'd1;
      8'h05:   win_shift = 3'd2;
      8'h06:   win_shift = 3'd3;
      8'h07:   win_shift = 3'd4;
      default: win_shift = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        armed_i,
  input  logic        key_wr_i,
  input  logic [31:0] key_i,
  output logic        svc_o
);
  feed_st_t st_q, st_n;

  always_comb begin
    st_n  = st_q;
    svc_o = 1'b0;
    if (key_wr_i && armed_i) begin
      if (st_q == FEED_IDLE && key_i == FEED_ONE) begin
        st_n = FEED_ARMED;
      end else if (st_q == FEED_ARMED && key_i == FEED_TWO) begin
        st_n  = FEED_IDLE;
        svc_o = 1'b1;
      end else begin
        st_n = FEED_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= FEED_IDLE;
    else     st_q <= st_n;
  end

  // R5
  seq_done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    svc_o |=> (st_q == FEED_IDLE));
  // R6
  bad_key_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (key_wr_i && armed_i && key_i != FEED_ONE && key_i != FEED_TWO) |=> (st_q == FEED_IDLE));
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pre_wr_i,
  input  logic             win_wr_i,
  input  logic             react_wr_i,
  input  logic [31:0]      wdata_i,
  input  logic             load_i,
  output logic [PRE_W-1:0] pre_o,
  output logic [7:0]       win_o,
  output logic [7:0]       react_o,
  output logic             irq_sel_o,
  output logic             irq_sel_n_o
);
  logic [PRE_W-1:0] pre_q;
  logic [7:0]       win_q, react_q;
  logic             sel_q;

  assign irq_sel_n_o = load_i ? (react_q == REACT_IRQ) : sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '1;
      win_q   <= '0;
      react_q <= '0;
      sel_q   <= 1'b0;
    end else begin
      if (pre_wr_i)   pre_q   <= wdata_i[PRE_W-1:0];
      if (win_wr_i)   win_q   <= wdata_i[7:0];
      if (react_wr_i) react_q <= wdata_i[7:0];
      sel_q <= irq_sel_n_o;
    end
  end

  assign pre_o     = pre_q;
  assign win_o     = win_q;
  assign react_o   = react_q;
  assign irq_sel_o = sel_q;

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(sel_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] rel_i,
  input  logic [2:0]       wsh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             early_o
);
  logic [CNT_W-1:0] cnt_q, rel_q, thr_q;
  logic             live_q;

  assign expire_o = tick_i && en_i && !load_i && live_q && (cnt_q == '0);
  assign early_o  = cnt_q > thr_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      thr_q  <= '0;
      live_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= rel_i;
      rel_q  <= rel_i;
      thr_q  <= rel_i >> wsh_i;
      live_q <= 1'b1;
    end else if (tick_i && en_i) begin
      if (cnt_q != '0) cnt_q  <= cnt_q - 1'b1;
      else             live_q <= 1'b0;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= rel_q);
  // R8
  thr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    thr_q <= (rel_q >> 1));
  // R4
  dead_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !live_q |-> (cnt_q == '0));
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PRE_W     = 12,
  parameter int PRE_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              err_irq,
  output logic              rst_req
);
  localparam int CNT_W = PRE_W + PRE_SHIFT;

  logic hit_ctrl, hit_pre, hit_stat, hit_key, hit_cnt, hit_react, hit_win;
  assign hit_ctrl  = addr == ADDR_W'(OFS_CTRL);
  assign hit_pre   = addr == ADDR_W'(OFS_PRE);
  assign hit_stat  = addr == ADDR_W'(OFS_STAT);
  assign hit_key   = addr == ADDR_W'(OFS_KEY);
  assign hit_cnt   = addr == ADDR_W'(OFS_CNT);
  assign hit_react = addr == ADDR_W'(OFS_REACT);
  assign hit_win   = addr == ADDR_W'(OFS_WIN);

  logic             en_q, err_q, err_n, go, svc, load;
  logic             expire, early, sel_q, sel_n;
  logic [PRE_W-1:0] pre;
  logic [7:0]       win, react;
  logic [CNT_W-1:0] cnt, rel;
  logic [31:0]      rd_n;

  assign go   = wr_en && hit_ctrl && (wdata == EN_MAGIC) && !en_q;
  assign load = go || svc;
  assign rel  = {pre, {PRE_SHIFT{1'b0}}};

  wdt_keyseq u_keyseq (
    .clk(clk), .rst(rst), .armed_i(en_q), .key_wr_i(wr_en && hit_key),
    .key_i(wdata), .svc_o(svc)
  );

  wdt_cfg #(.PRE_W(PRE_W)) u_cfg (
    .clk(clk), .rst(rst),
    .pre_wr_i(wr_en && hit_pre), .win_wr_i(wr_en && hit_win),
    .react_wr_i(wr_en && hit_react), .wdata_i(wdata), .load_i(load),
    .pre_o(pre), .win_o(win), .react_o(react),
    .irq_sel_o(sel_q), .irq_sel_n_o(sel_n)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .en_i(en_q), .load_i(load),
    .rel_i(rel), .wsh_i(win_shift(win)), .cnt_o(cnt),
    .expire_o(expire), .early_o(early)
  );

  assign err_n = expire || (svc && early) ||
                 (err_q && !(wr_en && hit_stat && wdata[ERR_BIT]));

  always_comb begin
    rd_n = '0;
    if (hit_ctrl)  rd_n[0]       = en_q;
    if (hit_pre)   rd_n[PRE_W-1:0] = pre;
    if (hit_stat)  rd_n[ERR_BIT] = err_q;
    if (hit_cnt)   rd_n          = 32'(cnt);
    if (hit_react) rd_n[7:0]     = react;
    if (hit_win)   rd_n[7:0]     = win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      err_q   <= 1'b0;
      err_irq <= 1'b0;
      rst_req <= 1'b0;
      rdata   <= '0;
    end else begin
      if (go) en_q <= 1'b1;
      err_q   <= err_n;
      err_irq <= err_n && sel_n;
      rst_req <= err_n && !sel_n;
      if (rd_en) rdata <= rd_n;
    end
  end

  // R9
  one_reaction_chk: assert property (@(posedge clk) disable iff (rst)
    !(err_irq && rst_req));
  // R3
  stay_on_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> en_q);
  // R11
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_en && hit_stat && wdata[ERR_BIT])) |=> err_q);
  // R9
  out_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    (err_irq || rst_req) == err_q);
  // R5
  no_feed_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !svc);
endmodule

// File: tb/test_win_wdog.sv
`timescale 1ns/1ps
module test_win_wdog;
  localparam int SH = 2;
  localparam logic [7:0] A_CTRL = 8'h90, A_PRE = 8'h94, A_STAT = 8'h98,
    A_KEY = 8'h9C, A_CNT = 8'hA0, A_REACT = 8'hA4, A_WIN = 8'hA8;

  logic clk = 0, rst = 1, tick = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic err_irq, rst_req;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  win_wdog #(.ADDR_W(8), .PRE_W(12), .PRE_SHIFT(SH)) i_win_wdog (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err_irq(err_irq), .rst_req(rst_req)
  );

  // reference state
  bit m_en, m_key, m_live, m_err, m_sel;
  int m_cnt, m_thr, m_pre, m_win, m_react;

  function automatic int shift_of(int code);
    case (code)
      'h50: return 1; 'h05: return 2; 'h06: return 3; 'h07: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] ref_read(logic [7:0] a);
    case (a)
      A_CTRL:  return {31'b0, m_en};
      A_PRE:   return 32'(m_pre);
      A_STAT:  return m_err ? 32'h2 : 32'h0;
      A_CNT:   return 32'(m_cnt);
      A_REACT: return 32'(m_react);
      A_WIN:   return 32'(m_win);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ref_reset();
    m_en = 0; m_key = 0; m_live = 0; m_err = 0; m_sel = 0;
    m_cnt = 0; m_thr = 0; m_pre = 'hFFF; m_win = 0; m_react = 0;
  endtask

  // one bus cycle; called right after a falling edge
  task automatic cyc(string tag, bit w, bit r, logic [7:0] a, logic [31:0] d, bit t);
    logic [31:0] rexp;
    bit svc, go, eset;
    rexp = ref_read(a);
    svc = 0; eset = 0;
    if (w && a == A_KEY && m_en) begin
      if (!m_key && d == 32'hE51A) m_key = 1;
      else if (m_key && d == 32'hA35C) begin m_key = 0; svc = 1; end
      else m_key = 0;
    end
    go = w && a == A_CTRL && d == 32'hA98559DA && !m_en;
    if (go || svc) begin
      if (svc && m_cnt > m_thr) eset = 1;
      m_cnt = m_pre << SH; m_thr = m_cnt >> shift_of(m_win);
      m_sel = (m_react == 'h0A); m_live = 1;
    end else if (t && m_en) begin
      if (m_cnt != 0) m_cnt--;
      else if (m_live) begin m_live = 0; eset = 1; end
    end
    m_err = eset || (m_err && !(w && a == A_STAT && d[1]));
    if (go) m_en = 1;
    if (w && a == A_PRE)   m_pre = int'(d[11:0]);
    if (w && a == A_WIN)   m_win = int'(d[7:0]);
    if (w && a == A_REACT) m_react = int'(d[7:0]);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick = t;
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_en = 0; tick = 0;
    if (r) check({tag, " read"}, rdata, rexp);
    check({tag, " R9 irq"}, {31'b0, err_irq}, {31'b0, m_err && m_sel});
    check({tag, " R9 rst"}, {31'b0, rst_req}, {31'b0, m_err && !m_sel});
  endtask

  task automatic wr(string tag, logic [7:0] a, logic [31:0] d); cyc(tag, 1, 0, a, d, 0); endtask
  task automatic rd(string tag, logic [7:0] a); cyc(tag, 0, 1, a, 0, 0); endtask
  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 8'h00, 0, 1);
  endtask
  task automatic feed(string tag);
    wr(tag, A_KEY, 32'hE51A); wr(tag, A_KEY, 32'hA35C);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ref_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 R13 reset values and unmapped read
    rd("R1 ctrl", A_CTRL); rd("R1 pre", A_PRE); rd("R1 stat", A_STAT);
    rd("R1 cnt", A_CNT); rd("R1 react", A_REACT); rd("R1 win", A_WIN);
    rd("R13 unmapped", 8'h44);
    // R5 keys ignored before enable
    feed("R5 pre-enable"); ticks("R5", 2); rd("R5 cnt idle", A_CNT);
    wr("R2", A_PRE, 5);
    wr("R2 bad magic", A_CTRL, 32'h12345678); rd("R2 still off", A_CTRL);
    wr("R2 good magic", A_CTRL, 32'hA98559DA);
    rd("R12 enabled", A_CTRL); rd("R2 loaded", A_CNT);
    ticks("R4", 4); rd("R4 decrement", A_CNT);
    feed("R7 early"); rd("R7 status", A_STAT); rd("R7 reloaded", A_CNT);
    wr("R11 clear", A_STAT, 32'h2); rd("R11 cleared", A_STAT);
    wr("R10 react", A_REACT, 8'h0A);
    ticks("R5", 12); feed("R5 in window"); rd("R5 reload", A_CNT); rd("R5 no err", A_STAT);
    ticks("R6", 3);
    wr("R6", A_KEY, 32'hE51A); wr("R6", A_KEY, 32'h1234); wr("R6", A_KEY, 32'hA35C);
    rd("R6 no reload", A_CNT);
    wr("R6", A_KEY, 32'hE51A); wr("R6", A_KEY, 32'hE51A); wr("R6", A_KEY, 32'hA35C);
    rd("R6 double first", A_CNT);
    wr("R3", A_CTRL, 0); rd("R3 still on", A_CTRL);
    wr("R3", A_CTRL, 32'hA98559DA); rd("R3 no reload", A_CNT);
    wr("R8", A_WIN, 8'h07); ticks("R8", 10); feed("R8 apply");
    ticks("R8", 12); feed("R8 early small window"); rd("R8 status", A_STAT);
    wr("R11", A_STAT, 2);
    ticks("R4 expire", 22); rd("R4 expired", A_STAT); rd("R4 zero", A_CNT);
    wr("R11", A_STAT, 2); ticks("R4 once", 3); rd("R4 no re-raise", A_STAT);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 45)      ticks("R4 rnd", 1);
      else if (op < 60) wr("R5 rnd", A_KEY, 32'hE51A);
      else if (op < 75) wr("R5 rnd", A_KEY, 32'hA35C);
      else if (op < 78) wr("R6 rnd", A_KEY, $urandom());
      else if (op < 82) wr("R11 rnd", A_STAT, 32'h2);
      else if (op < 84) wr("R10 rnd", A_PRE, $urandom_range(0, 8));
      else if (op < 86) begin
        int c; c = $urandom_range(0, 4);
        wr("R8 rnd", A_WIN, c == 0 ? 'h50 : c == 1 ? 'h05 : c == 2 ? 'h06 : c == 3 ? 'h07 : 'h33);
      end
      else if (op < 88) wr("R9 rnd", A_REACT, $urandom_range(0, 1) ? 'h0A : 'h11);
      else if (op < 93) rd("R4 rnd", A_CNT);
      else if (op < 97) rd("R11 rnd", A_STAT);
      else              cyc("R11 rnd", 1, 0, A_STAT, 2, 1);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule